// File: doc/BRIEF.md
# Nibble-to-Byte Packing Bridge

This block joins a narrow sender to a wider receiver that run on the same clock. The sender presents one nibble at a time on `nib_in` and marks each one with a pulse on `nib_vld`. The bridge collects two nibbles in turn. It then presents them together as one word on `byte_out`, with a single-cycle strobe on `byte_vld`. The first nibble of a pair fills the low half of the word and the second nibble fills the high half.

A controller state machine watches the level of `nib_vld`. It captures a nibble once, near the start of each pulse, and then refuses to take another until the strobe has dropped back to low. A sender that holds `nib_vld` high for many cycles therefore delivers exactly one nibble. The receiver never stalls the bridge. The word stays on `byte_out` until the next pair is complete. The nibble width is a parameter, and the word is always twice as wide.

Top module: `nibble_pack_bridge`

## Requirements
- R1: While `rst_n` is low at a rising edge, the bridge returns to waiting for a first nibble, and after that edge `byte_out` is all zeros and `byte_vld` is 0.
- R2: Each word is `{second nibble, first nibble}`. With NIB_W=4 the first nibble appears on `byte_out[3:0]` and the second on `byte_out[7:4]`.
- R3: `byte_vld` is high for exactly one clock cycle per completed pair and is never high in two consecutive cycles. The number of strobes equals the number of completed pairs.
- R4: A nibble strobe held high for any number of cycles yields exactly one captured nibble. The next nibble is accepted only after `nib_vld` has been sampled low.
- R5: The captured value is `nib_in` at the rising edge that follows the first edge at which `nib_vld` is sampled high. Values on `nib_in` at any other time have no effect on the result.
- R6: `byte_out` changes only in the cycle in which `byte_vld` is high. Otherwise it holds the last word.
- R7: `byte_vld` is high in the cycle after the first rising edge that meets both of these conditions: it lies at least two edges after the edge that first samples the second nibble's strobe high, and `nib_vld` is sampled low there. At that edge `nib_vld` was low.
- R8: A reset during assembly discards a partly received pair. The next two nibbles form a fresh word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by sender, bridge and receiver |
| rst_n | input | 1 | Synchronous reset, active low |
| nib_in | input | NIB_W | Nibble data from the sender |
| nib_vld | input | 1 | Sender strobe marking a nibble, one pulse per nibble |
| byte_out | output | 2*NIB_W | Packed word, held between completions |
| byte_vld | output | 1 | Single-cycle strobe marking a new word |

## Verification
The bench builds the bridge with the default NIB_W=4, so an 8-bit word is assembled. At this width the all-zero and all-ones nibbles and several mixed patterns can be driven directly. The stimulus varies the strobe lengths from one cycle to fifteen cycles and also varies the gaps between strobes. This covers both a drain state that exits at once and one that waits through a long held-high strobe. Garbage is placed on `nib_in` outside the capture edge, which shows that only the defined sample point matters. A reset in the middle of a pair shows that the partial nibble is dropped.

// File: rtl/nbp_pkg.sv
// Shared definitions for the nibble packing bridge.
// Assumes: the controller state encoding is private to the bridge.
package nbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_LO  = 3'd0,
        ST_TAKE_LO  = 3'd1,
        ST_DRAIN_LO = 3'd2,
        ST_IDLE_HI  = 3'd3,
        ST_TAKE_HI  = 3'd4,
        ST_DRAIN_HI = 3'd5,
        ST_EMIT     = 3'd6,
        ST_EMIT_END = 3'd7
    } nbp_state_e;

endpackage

// File: rtl/nbp_ctrl.sv
// Sequencer for the packing bridge. It reacts to the level of the
// sender strobe, issues one load per strobe and waits for the strobe
// to fall before it accepts the next one.
// Assumes: nib_vld is synchronous to clk. Reset is synchronous and active low.
module nbp_ctrl
    import nbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nib_vld,
    output logic lo_ld,
    output logic hi_ld,
    output logic out_ld,
    output logic emit
);

    nbp_state_e state_q;
    nbp_state_e state_d;

    // State register with synchronous reset to the first idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection driven by the strobe level.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE_LO:  if (nib_vld) state_d = ST_TAKE_LO;
            ST_TAKE_LO:  state_d = ST_DRAIN_LO;
            ST_DRAIN_LO: if (!nib_vld) state_d = ST_IDLE_HI;
            ST_IDLE_HI:  if (nib_vld) state_d = ST_TAKE_HI;
            ST_TAKE_HI:  state_d = ST_DRAIN_HI;
            ST_DRAIN_HI: if (!nib_vld) state_d = ST_EMIT;
            ST_EMIT:     state_d = ST_EMIT_END;
            ST_EMIT_END: state_d = ST_IDLE_LO;
            default:     state_d = ST_IDLE_LO;
        endcase
    end

    // Load enables and output strobe decoded from the current state.
    always_comb begin
        lo_ld  = (state_q == ST_TAKE_LO);
        hi_ld  = (state_q == ST_TAKE_HI);
        out_ld = (state_q == ST_DRAIN_HI) && !nib_vld;
        emit   = (state_q == ST_EMIT);
    end

endmodule

// File: rtl/nbp_field_reg.sv
// Loadable register with synchronous clear. It holds its value
// whenever the load enable is low.
// Assumes: active-low synchronous reset.
module nbp_field_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture on load, clear on reset, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/nibble_pack_bridge.sv
// Top of the packing bridge. Two nibble slots built by a generate loop
// are filled in turn. An output register then presents them as one
// word, together with a single-cycle strobe.
// Assumes: sender and receiver share clk, and the receiver never stalls.
module nibble_pack_bridge #(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIB_W-1:0]     nib_in,
    input  logic                 nib_vld,
    output logic [2*NIB_W-1:0]   byte_out,
    output logic                 byte_vld
);

    localparam int SLOTS  = 2;
    localparam int WORD_W = SLOTS * NIB_W;

    logic             lo_ld;
    logic             hi_ld;
    logic             out_ld;
    logic [SLOTS-1:0] slot_ld;
    logic [WORD_W-1:0] packed_word;

    nbp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_vld (nib_vld),
        .lo_ld   (lo_ld),
        .hi_ld   (hi_ld),
        .out_ld  (out_ld),
        .emit    (byte_vld)
    );

    assign slot_ld = {hi_ld, lo_ld};

    // One register per nibble slot. Slot 0 is the low half of the word.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        nbp_field_reg #(.W(NIB_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (slot_ld[g]),
            .d     (nib_in),
            .q     (packed_word[g*NIB_W +: NIB_W])
        );
    end

    nbp_field_reg #(.W(WORD_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (out_ld),
        .d     (packed_word),
        .q     (byte_out)
    );

endmodule

// File: rtl/nbp_bridge_chk.sv
// Property checker for the packing bridge, attached by bind.
// Assumes: it observes the top-level ports only.
module nbp_bridge_chk #(
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nib_vld,
    input logic [2*NIB_W-1:0] byte_out,
    input logic               byte_vld
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (byte_vld == 1'b0 && byte_out == '0)); // R1

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(byte_out)) |-> byte_vld); // R6

    AST_EMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_vld) |-> !$past(nib_vld)); // R7

endmodule

bind nibble_pack_bridge nbp_bridge_chk #(.NIB_W(NIB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nib_vld  (nib_vld),
    .byte_out (byte_out),
    .byte_vld (byte_vld)
);

// File: tb/tb_nibble_pack_bridge.sv
`timescale 1ns/1ps
module tb_nibble_pack_bridge;

    localparam int NIB_W = 4;
    localparam int NVEC  = 8;

    // Fields: first nib, second nib, len1, gap, len2, idle (4 bits each)
    localparam logic [23:0] VEC [NVEC] = '{
        24'h3A_1113, 24'hF0_2133, 24'h0F_C214, 24'h5C_1593,
        24'h96_4143, 24'hE1_3715, 24'h77_F1F3, 24'h00_1113
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NIB_W-1:0] nib_in;
    logic             nib_vld;
    logic [7:0]       byte_out;
    logic             byte_vld;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [0:31];
    int wr_i = 0;
    int rd_i = 0;
    logic prev_vld = 1'b0;

    always #2.5 clk = ~clk;

    nibble_pack_bridge #(.NIB_W(NIB_W)) dut (
        .clk(clk), .rst_n(rst_n), .nib_in(nib_in), .nib_vld(nib_vld),
        .byte_out(byte_out), .byte_vld(byte_vld)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse nib_vld for len edges. Data is held through the capture edge and scrambled afterwards.
    task automatic send_nib(input logic [3:0] d, input int len);
        int last;
        last = (len < 2) ? 2 : len;
        nib_in  = d;
        nib_vld = 1'b1;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            if (k >= len) nib_vld = 1'b0;
            if (k >= 2)   nib_in  = ~d;
        end
        @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] b);
        exp_q[wr_i] = b;
        wr_i++;
    endtask

    // Strobe monitor: compares each word with the expected queue (R2, R3, R5).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && byte_vld === 1'b1) begin
            check(prev_vld == 1'b0, "R3 strobe one cycle", 1, 0);
            if (rd_i < wr_i) begin
                check(byte_out == exp_q[rd_i], "R2/R5 packed word", byte_out, exp_q[rd_i]);
            end else begin
                check(1'b0, "R3 unexpected strobe", rd_i, wr_i);
            end
            rd_i++;
        end
        prev_vld = byte_vld;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        rst_n = 1'b0; nib_vld = 1'b0; nib_in = '0;
        repeat (3) @(negedge clk);
        check(byte_out == 8'h00, "R1 reset word", byte_out, 0);
        check(byte_vld == 1'b0, "R1 reset strobe", byte_vld, 0);
        rst_n = 1'b1;
        nib_in = 4'h9;                 // R5: noise while idle is ignored
        repeat (2) @(negedge clk);

        // Table walk: R2, R4 (long held strobes), R5 (scrambled data)
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e;
            e = VEC[v];
            expect_byte({e[19:16], e[23:20]});
            send_nib(e[23:20], int'(e[15:12]));
            repeat (int'(e[11:8])) @(negedge clk);
            send_nib(e[19:16], int'(e[7:4]));
            repeat (int'(e[3:0])) @(negedge clk);
        end
        check(rd_i == NVEC, "R4 one word per pair", rd_i, NVEC);

        // R6: the word holds while idle
        held = byte_out;
        nib_in = 4'h5;
        repeat (6) @(negedge clk);
        check(byte_out == held, "R6 word holds", byte_out, held);

        // R7: latency with a single-cycle second strobe and with a held one
        expect_byte(8'h4D);
        send_nib(4'hD, 1);
        @(negedge clk);
        send_nib(4'h4, 1);
        check(byte_vld == 1'b1, "R7 strobe timing short", byte_vld, 1);
        repeat (3) @(negedge clk);
        expect_byte(8'hB6);
        send_nib(4'h6, 3);
        @(negedge clk);
        send_nib(4'hB, 7);
        check(byte_vld == 1'b1, "R7 strobe timing held", byte_vld, 1);
        repeat (3) @(negedge clk);

        // R8: reset after a first nibble drops it
        send_nib(4'h8, 2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(byte_out == 8'h00, "R8 reset clears word", byte_out, 0);
        check(byte_vld == 1'b0, "R8 reset clears strobe", byte_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_byte(8'hB2);
        send_nib(4'h2, 2);
        @(negedge clk);
        send_nib(4'hB, 2);
        repeat (4) @(negedge clk);

        check(rd_i == wr_i, "R3 strobe count", rd_i, wr_i);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule